// File: doc/BRIEF.md
# Byte-lane parity generator and checker

This block produces and checks one parity bit per byte of a 32-bit external data bus split into four byte lanes. On the write side it computes a parity bit for every lane of the outgoing data. Lanes that the current transfer does not use drive parity 0. On the read side it compares the parity bits sampled from the bus with the parity of each received byte. Only lanes taking part in the transfer are compared. A mismatch is recorded in a sticky error flag and a per-lane syndrome.

The lanes in use are computed for each transfer. A burst beat uses all four lanes. A single beat uses the two low address bits as the starting lane and a two-bit size code for the width. A size and address pair that cannot be aligned raises a misalignment output, and no lane is used. A configuration input selects the even or odd parity rule. A second input enables checking.

Top module: `lane_parity_unit`

## Requirements
- R1: Lane n covers data bits [31-8n : 24-8n], so lane 0 is the most significant byte, and parity bit n belongs to lane n. With `odd_sel`=0 (even) the parity bit is the XOR of the lane's eight bits. With `odd_sel`=1 (odd) it is the inverse of that XOR.
- R2: `wr_par_out` bit n carries the R1 parity of `wr_data` lane n when lane n is selected, and 0 when it is not. It is combinational from the inputs.
- R3: On a single beat (`burst`=0), `lane_mask` bit n marks lane n as selected, as follows. `tsize`=01 (byte) selects lane `addr_lo`. `tsize`=10 (halfword) selects lanes `addr_lo` and `addr_lo`+1. `tsize`=00 (word) selects all four lanes.
- R4: On a single beat, `misalign`=1 and `lane_mask`=0000 in three cases: a halfword with odd `addr_lo`, a word with `addr_lo`≠00, or `tsize`=11. Otherwise `misalign`=0.
- R5: With `burst`=1, `lane_mask`=1111 and `misalign`=0 whatever `tsize` and `addr_lo` are.
- R6: A read parity error is captured in a cycle where `ack`=1, `is_read`=1 and `chk_en`=1. A selected lane whose sampled `rd_par_in` bit differs from the R1 parity of `rd_data` sets `par_err`, and its bit in `err_lanes` is ORed in. Both outputs are registered and show the result after that clock edge.
- R7: Mismatches are ignored in four cases: in unselected lanes, or when `ack`=0, `is_read`=0 or `chk_en`=0. `par_err` and `err_lanes` keep their values.
- R8: `par_err` and `err_lanes` hold until a cycle with `err_clr`=1 clears them. In a cycle that both clears and captures, the result is only that cycle's new errors.
- R9: While `rst_n`=0 at a clock edge, `par_err` becomes 0 and `err_lanes` becomes 0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| odd_sel | input | 1 | 1 = odd parity, 0 = even parity |
| chk_en | input | 1 | Enables read parity checking |
| burst | input | 1 | Current beat is part of a burst |
| addr_lo | input | 2 | Two low address bits of the transfer |
| tsize | input | 2 | Size code: 01 byte, 10 halfword, 00 word |
| is_read | input | 1 | Current transfer is a read |
| ack | input | 1 | Transfer acknowledge sampled active this cycle |
| err_clr | input | 1 | Clears the sticky error state |
| wr_data | input | 32 | Outgoing write data |
| rd_data | input | 32 | Data sampled on a read |
| rd_par_in | input | 4 | Parity bits sampled on a read, bit n for lane n |
| wr_par_out | output | 4 | Generated write parity, bit n for lane n |
| lane_mask | output | 4 | Selected lanes, bit n for lane n |
| misalign | output | 1 | Size and address combination is misaligned |
| par_err | output | 1 | Sticky read parity error flag |
| err_lanes | output | 4 | Sticky per-lane error syndrome |

## Verification
Every combination of size code, low address, burst and parity sense is applied. For each one, a single-bit error is injected into each lane in turn, sometimes in the data and sometimes in the parity bit. This separates errors in selected lanes, which must be flagged, from errors in unselected lanes, which must be ignored. It also separates the two parity senses and checks that misaligned single beats check no lanes.

A fixed pattern with a known parity value pins down the lane order and the bit order. Directed sequences cover accumulation of errors across transfers, a clear in the same cycle as a capture, and each gating input (acknowledge, read and enable) held inactive. Random transfers with random clears are compared against a bench model of the sticky state.

// File: rtl/lane_parity_pkg.sv
// Shared types for the byte-lane parity unit.
// Assumes a transfer-size code of two bits.
package lane_parity_pkg;
    typedef enum logic [1:0] {
        SZ_WORD = 2'b00,
        SZ_BYTE = 2'b01,
        SZ_HALF = 2'b10,
        SZ_RSVD = 2'b11
    } size_e;
endpackage

// File: rtl/lane_select.sv
// Decodes the lanes a beat uses from the burst flag, the low address
// and the size code, and flags size/address pairs that cannot align.
// Assumes LANES is a power of two, at least 2.
module lane_select
    import lane_parity_pkg::*;
#(
    parameter int LANES = 4,
    localparam int AW = $clog2(LANES)
) (
    input  logic             burst,
    input  logic [AW-1:0]    addr,
    input  logic [1:0]       tsize,
    output logic [LANES-1:0] mask,
    output logic             misalign
);
    // Purpose: compute the lane mask and the misalignment flag.
    always_comb begin
        mask     = '0;
        misalign = 1'b0;
        if (burst) begin
            mask = '1;
        end else begin
            case (size_e'(tsize))
                SZ_BYTE: mask[addr] = 1'b1;
                SZ_HALF: begin
                    if (addr[0]) begin
                        misalign = 1'b1;
                    end else begin
                        mask[addr]          = 1'b1;
                        mask[addr + AW'(1)] = 1'b1;
                    end
                end
                SZ_WORD: begin
                    if (addr != '0) misalign = 1'b1;
                    else            mask     = '1;
                end
                default: misalign = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/byte_parity.sv
// Computes one parity bit per byte lane, with the even or odd rule.
// Lane 0 is the most significant byte of the word.
module byte_parity #(
    parameter int LANES  = 4,
    parameter int LANE_W = 8,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic [DATA_W-1:0] data,
    input  logic              odd,
    output logic [LANES-1:0]  par
);
    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            // Purpose: reduce lane g's bits and apply the parity sense.
            assign par[g] = (^data[DATA_W-1-g*LANE_W -: LANE_W]) ^ odd;
        end
    endgenerate
endmodule

// File: rtl/error_capture.sv
// Holds the sticky parity error flag and the per-lane syndrome.
// A clear wipes the old state; the same cycle's hits are still kept.
module error_capture #(
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] hit,
    input  logic             clr,
    output logic             flag,
    output logic [LANES-1:0] lanes
);
    // Purpose: accumulate lane hits until a clear, reset to empty.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag  <= 1'b0;
            lanes <= '0;
        end else begin
            flag  <= (clr ? 1'b0 : flag) | (|hit);
            lanes <= (clr ? '0 : lanes) | hit;
        end
    end
endmodule

// File: rtl/lane_parity_unit.sv
// Per-lane parity generation for writes and checking for reads on a
// byte-lane data bus. The lanes in use come from burst/size/address.
// Assumes ack marks the single cycle in which a read beat is valid.
module lane_parity_unit #(
    parameter int LANES  = 4,
    parameter int LANE_W = 8,
    localparam int DATA_W = LANES * LANE_W,
    localparam int AW     = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              odd_sel,
    input  logic              chk_en,
    input  logic              burst,
    input  logic [AW-1:0]     addr_lo,
    input  logic [1:0]        tsize,
    input  logic              is_read,
    input  logic              ack,
    input  logic              err_clr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] rd_data,
    input  logic [LANES-1:0]  rd_par_in,
    output logic [LANES-1:0]  wr_par_out,
    output logic [LANES-1:0]  lane_mask,
    output logic              misalign,
    output logic              par_err,
    output logic [LANES-1:0]  err_lanes
);
    logic [LANES-1:0] wr_par;
    logic [LANES-1:0] rd_exp;
    logic [LANES-1:0] hit;
    logic             sample;

    lane_select #(.LANES(LANES)) u_sel (
        .burst    (burst),
        .addr     (addr_lo),
        .tsize    (tsize),
        .mask     (lane_mask),
        .misalign (misalign)
    );

    byte_parity #(.LANES(LANES), .LANE_W(LANE_W)) u_wr_par (
        .data (wr_data),
        .odd  (odd_sel),
        .par  (wr_par)
    );

    byte_parity #(.LANES(LANES), .LANE_W(LANE_W)) u_rd_par (
        .data (rd_data),
        .odd  (odd_sel),
        .par  (rd_exp)
    );

    // Purpose: qualify a read beat for checking.
    assign sample = ack & is_read & chk_en;

    // Purpose: mismatches in selected lanes of a qualified beat.
    assign hit = (rd_exp ^ rd_par_in) & lane_mask & {LANES{sample}};

    // Purpose: drive parity only on lanes the transfer uses.
    assign wr_par_out = wr_par & lane_mask;

    error_capture #(.LANES(LANES)) u_err (
        .clk   (clk),
        .rst_n (rst_n),
        .hit   (hit),
        .clr   (err_clr),
        .flag  (par_err),
        .lanes (err_lanes)
    );
endmodule

// File: rtl/lane_parity_chk.sv
// Property checker for lane_parity_unit, attached through bind.
module lane_parity_chk #(
    parameter int LANES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             chk_en,
    input logic             burst,
    input logic [1:0]       tsize,
    input logic             is_read,
    input logic             ack,
    input logic             err_clr,
    input logic [LANES-1:0] wr_par_out,
    input logic [LANES-1:0] lane_mask,
    input logic             misalign,
    input logic             par_err,
    input logic [LANES-1:0] err_lanes
);
    assert_unsel_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_par_out & ~lane_mask) == '0);

    assert_byte_one_lane_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!burst && tsize == 2'b01) |-> $countones(lane_mask) == 1);

    assert_misalign_no_lanes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |-> lane_mask == '0);

    assert_burst_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
        burst |-> (lane_mask == '1 && !misalign));

    assert_flag_matches_lanes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        par_err == (err_lanes != '0));

    assert_ignored_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((!ack || !is_read || !chk_en) && !err_clr) |=> $stable(err_lanes));

    assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (par_err && !err_clr) |=> par_err);

    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr && !ack) |=> (err_lanes == '0 && !par_err));
endmodule

bind lane_parity_unit lane_parity_chk #(.LANES(LANES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .chk_en     (chk_en),
    .burst      (burst),
    .tsize      (tsize),
    .is_read    (is_read),
    .ack        (ack),
    .err_clr    (err_clr),
    .wr_par_out (wr_par_out),
    .lane_mask  (lane_mask),
    .misalign   (misalign),
    .par_err    (par_err),
    .err_lanes  (err_lanes)
);

// File: tb/sim_lane_parity_unit.sv
module sim_lane_parity_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        odd_sel, chk_en, burst, is_read, ack, err_clr;
    logic [1:0]  addr_lo, tsize;
    logic [31:0] wr_data, rd_data;
    logic [3:0]  rd_par_in;
    logic [3:0]  wr_par_out, lane_mask, err_lanes;
    logic        misalign, par_err;

    int checks = 0;
    int errors = 0;
    logic [3:0] model_lanes = 4'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lane_parity_unit u0 (
        .clk(clk), .rst_n(rst_n), .odd_sel(odd_sel), .chk_en(chk_en),
        .burst(burst), .addr_lo(addr_lo), .tsize(tsize), .is_read(is_read),
        .ack(ack), .err_clr(err_clr), .wr_data(wr_data), .rd_data(rd_data),
        .rd_par_in(rd_par_in), .wr_par_out(wr_par_out), .lane_mask(lane_mask),
        .misalign(misalign), .par_err(par_err), .err_lanes(err_lanes)
    );

    function automatic logic [3:0] exp_par(input logic [31:0] d, input logic odd);
        logic [3:0] p;
        for (int i = 0; i < 4; i++) p[i] = (^d[31-8*i -: 8]) ^ odd;
        return p;
    endfunction

    function automatic logic exp_mis(input logic b, input logic [1:0] a, input logic [1:0] ts);
        if (b) return 1'b0;
        case (ts)
            2'b01:   return 1'b0;
            2'b10:   return a[0];
            2'b00:   return a != 2'b00;
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic [3:0] exp_mask(input logic b, input logic [1:0] a, input logic [1:0] ts);
        if (b) return 4'b1111;
        if (exp_mis(b, a, ts)) return 4'b0000;
        case (ts)
            2'b01:   return 4'b0001 << a;
            2'b10:   return 4'b0011 << a;
            default: return 4'b1111;
        endcase
    endfunction

    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Applies one cycle of inputs at a falling edge, checks the decode and
    // write parity, then checks the registered error state one edge later.
    task automatic step(input logic b, input logic [1:0] a, input logic [1:0] ts,
                        input logic odd, input logic en, input logic rd,
                        input logic ak, input logic clr, input logic [31:0] wd,
                        input logic [31:0] rdd, input logic [3:0] rp, input string ftag);
        logic [3:0] m;
        logic [3:0] hit;
        string tag;
        burst = b; addr_lo = a; tsize = ts; odd_sel = odd; chk_en = en;
        is_read = rd; ack = ak; err_clr = clr; wr_data = wd; rd_data = rdd;
        rd_par_in = rp;
        #1;
        m = exp_mask(b, a, ts);
        tag = b ? "R5" : (exp_mis(b, a, ts) ? "R4" : "R3");
        check(lane_mask == m, tag, 32'(lane_mask), 32'(m));
        check(misalign == exp_mis(b, a, ts), tag, 32'(misalign), 32'(exp_mis(b, a, ts)));
        check(wr_par_out == (exp_par(wd, odd) & m), "R2", 32'(wr_par_out), 32'(exp_par(wd, odd) & m));
        hit = (exp_par(rdd, odd) ^ rp) & m & {4{ak & rd & en}};
        @(negedge clk);
        model_lanes = (clr ? 4'b0 : model_lanes) | hit;
        check(err_lanes == model_lanes, ftag, 32'(err_lanes), 32'(model_lanes));
        check(par_err == (model_lanes != 0), ftag, 32'(par_err), 32'(model_lanes != 0));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [3:0]  p;
        void'($urandom(32'd1234));
        rst_n = 1'b0; odd_sel = 0; chk_en = 0; burst = 0; addr_lo = 0; tsize = 0;
        is_read = 0; ack = 0; err_clr = 0; wr_data = 0; rd_data = 0; rd_par_in = 0;
        repeat (3) @(negedge clk);
        check(par_err == 1'b0, "R9", 32'(par_err), 0);
        check(err_lanes == 4'b0, "R9", 32'(err_lanes), 0);
        rst_n = 1'b1;

        // R1: fixed pattern pins lane and bit order, both senses.
        step(0, 2'd0, 2'b00, 0, 1, 0, 0, 0, 32'h0103_00FF, 0, 0, "R7");
        check(wr_par_out == 4'b0001, "R1", 32'(wr_par_out), 32'h1);
        step(0, 2'd0, 2'b00, 1, 1, 0, 0, 0, 32'h0103_00FF, 0, 0, "R7");
        check(wr_par_out == 4'b1110, "R1", 32'(wr_par_out), 32'he);

        // R6 R7: every combination, one single-bit error per lane in turn.
        for (int b = 0; b < 2; b++)
            for (int ts = 0; ts < 4; ts++)
                for (int a = 0; a < 4; a++)
                    for (int o = 0; o < 2; o++)
                        for (int ln = 0; ln < 4; ln++) begin
                            d = $urandom;
                            p = exp_par(d, o[0]);
                            if (ln[0]) p[ln] = ~p[ln];
                            else d[31-8*ln-($urandom%8)] ^= 1'b1;
                            step(b[0], a[1:0], ts[1:0], o[0], 1, 0, 0, 1, $urandom, 0, 0, "R8");
                            step(b[0], a[1:0], ts[1:0], o[0], 1, 1, 1, 0, $urandom, d, p, "R6");
                        end

        // R8: accumulation, hold, clear with same-cycle capture.
        step(0, 2'd0, 2'b00, 0, 1, 0, 0, 1, 0, 0, 0, "R8");
        d = 32'h5A5A_5A5A; p = exp_par(d, 0);
        step(0, 2'd1, 2'b01, 0, 1, 1, 1, 0, 0, d, p ^ 4'b0010, "R6");
        check(err_lanes == 4'b0010, "R6", 32'(err_lanes), 32'h2);
        step(0, 2'd3, 2'b01, 0, 1, 1, 1, 0, 0, d, p ^ 4'b1000, "R8");
        check(err_lanes == 4'b1010, "R8", 32'(err_lanes), 32'ha);
        step(1, 2'd0, 2'b00, 0, 1, 1, 1, 0, 0, d, p, "R8");
        check(err_lanes == 4'b1010, "R8", 32'(err_lanes), 32'ha);
        step(1, 2'd0, 2'b00, 0, 1, 1, 1, 1, 0, d, p ^ 4'b0001, "R8");
        check(err_lanes == 4'b0001, "R8", 32'(err_lanes), 32'h1);

        // R7: each gating input inactive, and an unselected lane.
        step(0, 2'd0, 2'b00, 0, 1, 0, 0, 1, 0, 0, 0, "R8");
        step(1, 2'd0, 2'b00, 0, 0, 1, 1, 0, 0, d, ~p, "R7");
        step(1, 2'd0, 2'b00, 0, 1, 0, 1, 0, 0, d, ~p, "R7");
        step(1, 2'd0, 2'b00, 0, 1, 1, 0, 0, 0, d, ~p, "R7");
        step(0, 2'd2, 2'b10, 0, 1, 1, 1, 0, 0, d, p ^ 4'b0011, "R7");
        check(err_lanes == 4'b0000, "R7", 32'(err_lanes), 0);

        // Random transfers with random clears.
        for (int i = 0; i < 400; i++) begin
            d = $urandom;
            p = exp_par(d, 1'($urandom)) ^ 4'(($urandom % 3 == 0) ? (1 << ($urandom % 4)) : 0);
            step(1'($urandom % 4 == 0), 2'($urandom), 2'($urandom), 1'($urandom),
                 1'($urandom % 4 != 0), 1'($urandom % 4 != 0), 1'($urandom),
                 1'($urandom % 8 == 0), $urandom, d, p, "R6");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule